// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block is a passive observer for the command bus of a multi-bank SDRAM. It defaults to two banks. On every rising clock edge it samples the chip select, row strobe, column strobe, write enable, clock enable and address pins, and turns them into a command. It keeps its own picture of every bank: whether a row is open and which row that is. It never drives the bus and never models stored data.

Each command starts timing windows: a per-bank precharge window, a global window after an auto-refresh and a global window after a mode register load. Reads and writes that request auto-precharge close their bank when the burst ends. A tumbling window counts refreshes to check that the refresh rate is met. Each broken rule sets its own sticky bit in an error vector, and the bits stay set until the clear input is pulsed. The block is meant to sit next to a memory controller in simulation or in silicon debug logic, where it reports the first protocol violations the controller makes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from the active-low pins {ras_n,cas_n,we_n} while cs_n is low: 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode load, 111 no-op. While cs_n is high the cycle is a deselect: it has no effect on bank state or error bits, whatever the other pins carry.
- R2: An activate opens the bank selected by the top address bits (addr[11] by default). One cycle later bank_active shows that bank open, and its field in open_rows (bank b at bits b*11 and up) holds addr[10:0].
- R3: A read or write to a bank that is not open sets error bit 0 (access to a closed bank).
- R4: An activate to a bank that is already open sets error bit 1.
- R5: A mode load, or an auto-refresh, issued while any bank is open sets error bit 2.
- R6: A command aimed at a bank fewer than T_RP cycles after that bank was precharged sets error bit 3. Activate, read and write aim at one bank. Precharge aims at one bank, or at all banks when addr[10] is high. Refresh and mode load aim at all banks. A command exactly T_RP cycles later is legal.
- R7: Any command (anything but no-op or deselect) fewer than T_RC cycles after an auto-refresh sets error bit 4. A command exactly T_RC cycles later is legal.
- R8: Any command fewer than T_MCD cycles after a mode load sets error bit 5. A command exactly T_MCD cycles later is legal.
- R9: A read or write with addr[10] high to an open bank closes that bank BURST_LEN cycles after the command, and that closing starts the bank's T_RP window. With addr[10] low the bank stays open.
- R10: A precharge with addr[10] high closes every bank. With addr[10] low it closes only the selected bank.
- R11: The REF_WINDOW cycles after reset form one window, and each following run of REF_WINDOW cycles forms the next. At the end of each window, error bit 6 is set if fewer than REF_MIN auto-refreshes fell inside it.
- R12: Error bits are sticky until err_clr is high for a cycle. Errors detected in that same cycle are still recorded. err_any is high exactly when some error bit is set.
- R13: The auto-refresh pattern counts as a refresh only while cke is high. With cke low it starts no refresh window and raises no open-bank error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address pins (bank, auto-precharge flag, row) |
| err_clr | input | 1 | Pulse high to clear the error vector |
| err_vec | output | 7 | Sticky error bits, one per rule |
| err_any | output | 1 | OR of all error bits |
| bank_active | output | NUM_BANKS | One bit per bank, high while a row is open |
| open_rows | output | NUM_BANKS*ROW_W | Open row of each bank, packed by bank index |

## Verification
Errors in the bank model show up on bank_active one cycle after the command that caused them. A wrong close time after an auto-precharge burst moves the bank_active fall away from the expected cycle, and it also moves the cycle from which a new activate stops raising bit 3. Timing counters with an off-by-one error show up as a wrong error bit in the first or last legal cycle of a window, so the bench always issues commands one cycle inside each window and exactly on its edge. A refresh count that is wrong can only be seen at a window boundary, so the bench samples bit 6 on both sides of that edge.

// File: rtl/sdrmon_pkg.sv
package sdrmon_pkg;
   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS,
      CMD_OTHER
   } cmd_e;

   localparam int ERR_RW_IDLE  = 0;
   localparam int ERR_ACT_OPEN = 1;
   localparam int ERR_NOT_IDLE = 2;
   localparam int ERR_TRP      = 3;
   localparam int ERR_TRC      = 4;
   localparam int ERR_TMCD     = 5;
   localparam int ERR_REF_RATE = 6;
   localparam int NUM_ERR      = 7;
endpackage

// File: rtl/sdrmon_decode.sv
module sdrmon_decode
   import sdrmon_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_NONE;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NONE;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = cke ? CMD_REF : CMD_OTHER;
            3'b000:  cmd = CMD_MRS;
            default: cmd = CMD_OTHER;
         endcase
      end
   end
endmodule

// File: rtl/sdrmon_gap.sv
module sdrmon_gap #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   generate
      if (GAP <= 1) begin : g_none
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, load};
         assign busy      = 1'b0;
      end else begin : g_cnt
         localparam int CW = $clog2(GAP);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (load)         cnt <= CW'(GAP - 1);
            else if (cnt != '0)    cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/sdrmon_bank.sv
module sdrmon_bank #(
   parameter int ROW_W     = 11,
   parameter int T_RP      = 3,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_hit,
   input  logic             pre_hit,
   input  logic             ap_hit,
   input  logic [ROW_W-1:0] row_in,
   output logic             active,
   output logic [ROW_W-1:0] row,
   output logic             trp_busy
);
   localparam int AP_CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   logic             ap_pend;
   logic [AP_CW-1:0] ap_cnt;
   logic             ap_done;

   assign ap_done = ap_pend && (ap_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ap_pend <= 1'b0;
         ap_cnt  <= '0;
      end else if (pre_hit) begin
         ap_pend <= 1'b0;
      end else if (ap_hit) begin
         ap_pend <= 1'b1;
         ap_cnt  <= AP_CW'(BURST_LEN - 1);
      end else if (ap_pend) begin
         if (ap_cnt == '0) ap_pend <= 1'b0;
         else              ap_cnt  <= ap_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         row    <= '0;
      end else begin
         if (pre_hit || ap_done) active <= 1'b0;
         else if (act_hit)       active <= 1'b1;
         if (act_hit)            row    <= row_in;
      end
   end

   sdrmon_gap #(.GAP(T_RP)) u_trp (
      .clk  (clk),
      .rst_n(rst_n),
      .load (pre_hit || ap_done),
      .busy (trp_busy)
   );
endmodule

// File: rtl/sdrmon_ref_rate.sv
module sdrmon_ref_rate #(
   parameter int WINDOW   = 3_200_000,
   parameter int MIN_REFS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_seen,
   output logic short_win
);
   localparam int WCW = $clog2(WINDOW);
   localparam int RCW = $clog2(MIN_REFS + 1);

   logic [WCW-1:0] wcnt;
   logic [RCW-1:0] rcnt;
   logic           win_end;

   assign win_end   = (wcnt == WCW'(WINDOW - 1));
   assign short_win = win_end && ((int'(rcnt) + int'(ref_seen)) < MIN_REFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         rcnt <= '0;
      end else if (win_end) begin
         wcnt <= '0;
         rcnt <= '0;
      end else begin
         wcnt <= wcnt + 1'b1;
         if (ref_seen && (int'(rcnt) < MIN_REFS)) rcnt <= rcnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdrmon_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_BANKS  = 2,
   parameter int AP_BIT     = 10,
   parameter int T_RP       = 3,
   parameter int T_RC       = 6,
   parameter int T_MCD      = 2,
   parameter int BURST_LEN  = 4,
   parameter int REF_WINDOW = 3_200_000,
   parameter int REF_MIN    = 4096,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int ROW_W     = ADDR_W - BANK_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       err_clr,
   output logic [NUM_ERR-1:0]         err_vec,
   output logic                       err_any,
   output logic [NUM_BANKS-1:0]       bank_active,
   output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ROW_W) begin : g_bad_ap
      $error("AP_BIT must lie below the bank select bits");
   end
   if (T_RP < 1 || T_RC < 1 || T_MCD < 1 || BURST_LEN < 1) begin : g_bad_timing
      $error("timing parameters must be at least 1");
   end
   if (REF_WINDOW < 2 || REF_MIN < 1) begin : g_bad_ref
      $error("refresh window must be at least 2 cycles and REF_MIN at least 1");
   end

   cmd_e              cmd;
   logic [BANK_W-1:0] bank_sel;
   logic              ap_flag;
   logic              any_cmd;
   logic              is_rw;
   logic [NUM_BANKS-1:0] aimed;
   logic [NUM_BANKS-1:0] trp_busy;
   logic              trc_busy;
   logic              tmcd_busy;
   logic              ref_short;
   logic [NUM_ERR-1:0] err_new;
   logic [NUM_ERR-1:0] err_q;

   sdrmon_decode u_dec (
      .cke  (cke),
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   assign bank_sel = addr[ADDR_W-1 -: BANK_W];
   assign ap_flag  = addr[AP_BIT];
   assign any_cmd  = (cmd != CMD_NONE);
   assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      logic act_hit;
      logic pre_hit;
      logic ap_hit;
      logic [ROW_W-1:0] row_q;

      assign hit     = (bank_sel == BANK_W'(b));
      assign act_hit = (cmd == CMD_ACT) && hit;
      assign pre_hit = (cmd == CMD_PRE) && (ap_flag || hit);
      assign ap_hit  = is_rw && hit && ap_flag && bank_active[b];
      assign aimed[b] = ((cmd == CMD_ACT || is_rw) && hit) || pre_hit
                        || (cmd == CMD_REF) || (cmd == CMD_MRS);

      sdrmon_bank #(
         .ROW_W    (ROW_W),
         .T_RP     (T_RP),
         .BURST_LEN(BURST_LEN)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_hit (act_hit),
         .pre_hit (pre_hit),
         .ap_hit  (ap_hit),
         .row_in  (addr[ROW_W-1:0]),
         .active  (bank_active[b]),
         .row     (row_q),
         .trp_busy(trp_busy[b])
      );

      assign open_rows[b*ROW_W +: ROW_W] = row_q;
   end

   sdrmon_gap #(.GAP(T_RC)) u_trc (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cmd == CMD_REF),
      .busy (trc_busy)
   );

   sdrmon_gap #(.GAP(T_MCD)) u_tmcd (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cmd == CMD_MRS),
      .busy (tmcd_busy)
   );

   sdrmon_ref_rate #(
      .WINDOW  (REF_WINDOW),
      .MIN_REFS(REF_MIN)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_seen (cmd == CMD_REF),
      .short_win(ref_short)
   );

   always_comb begin
      err_new               = '0;
      err_new[ERR_RW_IDLE]  = is_rw && !bank_active[bank_sel];
      err_new[ERR_ACT_OPEN] = (cmd == CMD_ACT) && bank_active[bank_sel];
      err_new[ERR_NOT_IDLE] = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|bank_active);
      err_new[ERR_TRP]      = |(aimed & trp_busy);
      err_new[ERR_TRC]      = any_cmd && trc_busy;
      err_new[ERR_TMCD]     = any_cmd && tmcd_busy;
      err_new[ERR_REF_RATE] = ref_short;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= '0;
      else if (err_clr) err_q <= err_new;
      else              err_q <= err_q | err_new;
   end

   assign err_vec = err_q;
   assign err_any = |err_q;
endmodule

// File: rtl/sdrmon_checker.sv
module sdrmon_checker
   import sdrmon_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 2,
   parameter int AP_BIT    = 10,
   parameter int T_RC      = 6,
   parameter int BANK_W    = 1,
   parameter int ROW_W     = 11
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cke,
   input logic                       cs_n,
   input logic                       ras_n,
   input logic                       cas_n,
   input logic                       we_n,
   input logic [ADDR_W-1:0]          addr,
   input logic                       err_clr,
   input logic [NUM_ERR-1:0]         err_vec,
   input logic                       err_any,
   input logic [NUM_BANKS-1:0]       bank_active,
   input logic [NUM_BANKS*ROW_W-1:0] open_rows
);
   localparam logic [NUM_ERR-1:0] KEEP = ~(NUM_ERR'(1) << ERR_REF_RATE);

   logic              c_act, c_rd, c_wr, c_pre, c_ref, c_mrs, c_any;
   logic [BANK_W-1:0] bnk;
   logic              past_ok;
   logic              unused_ok;

   assign c_act = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign c_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
   assign c_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
   assign c_pre = !cs_n && !ras_n &&  cas_n && !we_n;
   assign c_ref = !cs_n && !ras_n && !cas_n &&  we_n && cke;
   assign c_mrs = !cs_n && !ras_n && !cas_n && !we_n;
   assign c_any = !cs_n && !(ras_n && cas_n && we_n);
   assign bnk   = addr[ADDR_W-1 -: BANK_W];
   assign unused_ok = err_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !err_clr) |=> ((err_vec & KEEP) == ($past(err_vec) & KEEP)));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (c_act && bnk == BANK_W'(b)) |=>
            (bank_active[b] && open_rows[b*ROW_W +: ROW_W] == $past(addr[ROW_W-1:0])));
   end

   assert_rw_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((c_rd || c_wr) && !bank_active[bnk]) |=> err_vec[ERR_RW_IDLE]);

   assert_act_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_act && bank_active[bnk]) |=> err_vec[ERR_ACT_OPEN]);

   assert_not_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((c_mrs || c_ref) && (|bank_active)) |=> err_vec[ERR_NOT_IDLE]);

   if (T_RC > 1) begin : g_trc
      assert_trc_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(c_ref) && c_any) |=> err_vec[ERR_TRC]);
   end

   assert_pre_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (c_pre && addr[AP_BIT]) |=> (bank_active == '0));

   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> ((err_vec & $past(err_vec)) == $past(err_vec)));
endmodule

bind sdram_cmd_monitor sdrmon_checker #(
   .ADDR_W   (ADDR_W),
   .NUM_BANKS(NUM_BANKS),
   .AP_BIT   (AP_BIT),
   .T_RC     (T_RC),
   .BANK_W   (BANK_W),
   .ROW_W    (ROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cke        (cke),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .addr       (addr),
   .err_clr    (err_clr),
   .err_vec    (err_vec),
   .err_any    (err_any),
   .bank_active(bank_active),
   .open_rows  (open_rows)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   bit main_done = 1'b0;
   bit rf_done = 1'b0;
   bit reported = 1'b0;

   // main instance
   logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [11:0] addr = '0;
   logic        err_clr = 1'b0;
   logic [6:0]  err_vec;
   logic        err_any;
   logic [1:0]  bank_active;
   logic [21:0] open_rows;

   sdram_cmd_monitor #(
      .ADDR_W(12), .NUM_BANKS(2), .AP_BIT(10), .T_RP(3), .T_RC(6), .T_MCD(2),
      .BURST_LEN(4), .REF_WINDOW(3_200_000), .REF_MIN(4096)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .err_clr(err_clr),
      .err_vec(err_vec), .err_any(err_any), .bank_active(bank_active),
      .open_rows(open_rows)
   );

   // refresh-rate instance with a short window
   logic        rf_cke = 1'b1, rf_cs_n = 1'b1, rf_ras_n = 1'b1, rf_cas_n = 1'b1, rf_we_n = 1'b1;
   logic [11:0] rf_addr = '0;
   logic        rf_clr = 1'b0;
   logic [6:0]  rf_err;
   logic        rf_any;
   logic [1:0]  rf_act;
   logic [21:0] rf_rows;

   sdram_cmd_monitor #(
      .ADDR_W(12), .NUM_BANKS(2), .AP_BIT(10), .T_RP(3), .T_RC(2), .T_MCD(2),
      .BURST_LEN(4), .REF_WINDOW(64), .REF_MIN(2)
   ) uut_rf (
      .clk(clk), .rst_n(rst_n), .cke(rf_cke), .cs_n(rf_cs_n), .ras_n(rf_ras_n),
      .cas_n(rf_cas_n), .we_n(rf_we_n), .addr(rf_addr), .err_clr(rf_clr),
      .err_vec(rf_err), .err_any(rf_any), .bank_active(rf_act),
      .open_rows(rf_rows)
   );

   typedef struct {
      int          due;
      logic [6:0]  err;
      logic [1:0]  act;
      bit          chk_rows;
      logic [21:0] rows;
      string       tag;
   } item_t;

   item_t sb[$];

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_at(input logic [6:0] e, input logic [1:0] a, input int d, input string tag);
      item_t it;
      it.due = cyc + d; it.err = e; it.act = a; it.chk_rows = 1'b0; it.rows = '0; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic expect_rows(input logic [1:0] a, input logic [21:0] r, input string tag);
      item_t it;
      it.due = cyc + 1; it.err = '0; it.act = a; it.chk_rows = 1'b1; it.rows = r; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare due items away from the active edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            check(err_vec == sb[i].err, {sb[i].tag, " err_vec"}, 32'(err_vec), 32'(sb[i].err));
            check(err_any == (sb[i].err != '0), {sb[i].tag, " err_any R12"}, 32'(err_any), 32'(sb[i].err != '0));
            check(bank_active == sb[i].act, {sb[i].tag, " bank_active"}, 32'(bank_active), 32'(sb[i].act));
            if (sb[i].chk_rows)
               check(open_rows == sb[i].rows, {sb[i].tag, " open_rows"}, 32'(open_rows), 32'(sb[i].rows));
            sb.delete(i);
         end
      end
   end

   // driver
   task automatic put(input logic c, input logic r, input logic ca, input logic w,
                      input logic k, input logic [11:0] a, input logic clr);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; addr = a; err_clr = clr;
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) put(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
   endtask
   task automatic clr();
      put(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 1'b1);
   endtask
   task automatic do_act(input bit b, input logic [10:0] row);
      put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, {b, row}, 1'b0);
   endtask
   task automatic do_rd(input bit b, input bit ap);
      put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {b, ap, 10'h010}, 1'b0);
   endtask
   task automatic do_wr(input bit b, input bit ap);
      put(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, {b, ap, 10'h020}, 1'b0);
   endtask
   task automatic do_pre(input bit b, input bit all);
      put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {b, all, 10'h000}, 1'b0);
   endtask
   task automatic do_ref(input bit k);
      put(1'b0, 1'b0, 1'b0, 1'b1, k, 12'h000, 1'b0);
   endtask
   task automatic do_mrs();
      put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h032, 1'b0);
   endtask

   // main sequence
   initial begin
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      rst_n = 1'b1;
      check(err_vec == '0, "reset err_vec", 32'(err_vec), 0);
      check(bank_active == '0, "reset bank_active", 32'(bank_active), 0);
      check(err_any == 1'b0, "reset err_any", 32'(err_any), 0);

      // R1: deselect carrying an activate pattern
      put(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0);
      expect_at(7'h00, 2'b00, 1, "R1 deselect");
      // R3, R12: access to closed banks, sticky then cleared
      do_rd(1'b0, 1'b0);
      expect_at(7'h01, 2'b00, 1, "R3 read idle");
      expect_at(7'h01, 2'b00, 3, "R12 sticky");
      nop(3);
      clr();
      expect_at(7'h00, 2'b00, 1, "R12 clear");
      do_wr(1'b1, 1'b0);
      expect_at(7'h01, 2'b00, 1, "R3 write idle");
      clr();
      expect_at(7'h00, 2'b00, 1, "R12 clear 2");
      // R2: open both banks
      do_act(1'b0, 11'h155);
      expect_rows(2'b01, {11'h000, 11'h155}, "R2 bank0");
      do_act(1'b1, 11'h2AA);
      expect_rows(2'b11, {11'h2AA, 11'h155}, "R2 bank1");
      // R4
      do_act(1'b0, 11'h001);
      expect_at(7'h02, 2'b11, 1, "R4 act open");
      clr();
      expect_at(7'h00, 2'b11, 1, "R4 clear");
      // R5
      do_mrs();
      expect_at(7'h04, 2'b11, 1, "R5 mrs open");
      nop(1);
      clr();
      expect_at(7'h00, 2'b11, 1, "R5 clear");
      do_ref(1'b1);
      expect_at(7'h04, 2'b11, 1, "R5 ref open");
      nop(5);
      clr();
      expect_at(7'h00, 2'b11, 1, "R5 clear 2");
      // R10, R6
      do_pre(1'b1, 1'b0);
      expect_at(7'h00, 2'b01, 1, "R10 single bank");
      do_act(1'b1, 11'h033);
      expect_at(7'h08, 2'b11, 1, "R6 inside tRP");
      clr();
      expect_at(7'h00, 2'b11, 1, "R6 clear");
      do_pre(1'b0, 1'b1);
      expect_at(7'h00, 2'b00, 1, "R10 all banks");
      nop(2);
      do_act(1'b0, 11'h044);
      expect_at(7'h00, 2'b01, 1, "R6 tRP boundary");
      // R9: auto-precharge
      do_rd(1'b0, 1'b0);
      expect_at(7'h00, 2'b01, 1, "R9 read stays open");
      expect_at(7'h00, 2'b01, 5, "R9 read stays open later");
      nop(5);
      do_rd(1'b0, 1'b1);
      expect_at(7'h00, 2'b01, 4, "R9 read ap last open cycle");
      expect_at(7'h00, 2'b00, 5, "R9 read ap closed");
      nop(4);
      do_act(1'b0, 11'h055);
      expect_at(7'h08, 2'b01, 1, "R9 ap starts tRP");
      clr();
      expect_at(7'h00, 2'b01, 1, "R9 clear");
      do_wr(1'b0, 1'b1);
      expect_at(7'h00, 2'b01, 4, "R9 write ap last open cycle");
      expect_at(7'h00, 2'b00, 5, "R9 write ap closed");
      nop(7);
      // R7
      do_ref(1'b1);
      expect_at(7'h00, 2'b00, 1, "R7 refresh idle");
      nop(4);
      do_act(1'b1, 11'h066);
      expect_at(7'h10, 2'b10, 1, "R7 inside tRC");
      clr();
      expect_at(7'h00, 2'b10, 1, "R7 clear");
      do_pre(1'b0, 1'b1);
      expect_at(7'h00, 2'b00, 1, "R7 close");
      nop(3);
      do_ref(1'b1);
      expect_at(7'h00, 2'b00, 1, "R7 refresh 2");
      nop(5);
      do_act(1'b1, 11'h077);
      expect_at(7'h00, 2'b10, 1, "R7 tRC boundary");
      // R8
      do_pre(1'b0, 1'b1);
      expect_at(7'h00, 2'b00, 1, "R8 close");
      nop(3);
      do_mrs();
      expect_at(7'h00, 2'b00, 1, "R8 mrs idle");
      do_act(1'b0, 11'h011);
      expect_at(7'h20, 2'b01, 1, "R8 inside tMCD");
      clr();
      expect_at(7'h00, 2'b01, 1, "R8 clear");
      do_pre(1'b0, 1'b1);
      expect_at(7'h00, 2'b00, 1, "R8 close 2");
      nop(3);
      do_mrs();
      expect_at(7'h00, 2'b00, 1, "R8 mrs 2");
      nop(1);
      do_act(1'b0, 11'h012);
      expect_at(7'h00, 2'b01, 1, "R8 tMCD boundary");
      // R13: refresh pattern with cke low
      do_ref(1'b0);
      expect_at(7'h00, 2'b01, 1, "R13 cke low no refresh");
      do_act(1'b1, 11'h013);
      expect_at(7'h00, 2'b11, 1, "R13 no tRC window");
      nop(3);
      check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
      main_done = 1'b1;
   end

   // R11 sequence on the short-window instance
   task automatic rf_at(input int n, input bit ref_cmd, input bit clr_cmd);
      while (cyc != n - 1) @(negedge clk);
      rf_cs_n = 1'b0; rf_ras_n = !ref_cmd; rf_cas_n = !ref_cmd; rf_we_n = 1'b1; rf_clr = clr_cmd;
      @(negedge clk);
      rf_ras_n = 1'b1; rf_cas_n = 1'b1; rf_clr = 1'b0;
   endtask

   task automatic rf_check_at(input int n, input logic [6:0] e, input string tag);
      while (cyc != n) @(negedge clk);
      check(rf_err == e, tag, 32'(rf_err), 32'(e));
   endtask

   initial begin
      wait (rst_n);
      @(negedge clk);
      rf_cs_n = 1'b0;
      rf_at(10, 1'b1, 1'b0);
      rf_at(20, 1'b1, 1'b0);
      rf_check_at(64, 7'h00, "R11 window met");
      rf_at(70, 1'b1, 1'b0);
      rf_check_at(127, 7'h00, "R11 before window end");
      rf_check_at(128, 7'h40, "R11 window short");
      rf_at(130, 1'b0, 1'b1);
      rf_check_at(131, 7'h00, "R11 cleared");
      rf_at(140, 1'b1, 1'b0);
      rf_at(150, 1'b1, 1'b0);
      rf_at(160, 1'b1, 1'b0);
      rf_check_at(192, 7'h00, "R11 third window met");
      rf_done = 1'b1;
   end

   initial begin
      wait (main_done && rf_done);
      @(negedge clk);
      report();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end
endmodule